// File: doc/BRIEF.md
# Real-Time Clock with Decrementer

This block keeps wall-clock time as a pair of 32-bit registers: a whole-seconds count and a count of nanoseconds into the current second. Next to the clock sits a 32-bit down-counter. Each asserted tick moves the clock forward by a fixed nanosecond step and moves the down-counter back by one. When the down-counter passes below zero it latches an interrupt request.

Software reaches all three registers through a register port selected by a numeric ID. Reads are combinational. Writes land on the clock edge and need the privilege input. Writes made without privilege are dropped and reported on a one-cycle error pulse. The down-counter has a second, read-only ID that code without privilege may read. The nanosecond register uses only a middle band of bits, so its count always moves in 128 ns units.

Top module: `rtc_dec_unit`

## Requirements
- R1: After reset the seconds register, the nanosecond register and the down-counter all read zero, and `irq` and `wr_err` are low.
- R2: Each clock edge with `tick_en` high adds 128 to the nanosecond register (ID 5). Bits 31:30 and 6:0 of that register (little-endian numbering) always read zero.
- R3: When the incremented nanosecond value is 1,000,000,000 or more, 1,000,000,000 is subtracted from it and the seconds register (ID 4) is incremented on the same edge. This also applies when the stored value was already out of range.
- R4: A write to ID 5 stores the write data ANDed with 0x3FFFFF80.
- R5: Each tick decrements the down-counter (read at ID 22) by one, wrapping from 0x00000000 to 0xFFFFFFFF.
- R6: `irq` rises on the edge where the down-counter goes from 0x00000000 to 0xFFFFFFFF. It stays high until an edge with `irq_ack` high, which clears it. If a new wrap happens on that same edge, `irq` stays high.
- R7: ID 6 returns the down-counter whatever the privilege level, and writes to ID 6 have no effect. ID 22 reads zero when `priv` is low. Any other unused ID reads zero and ignores writes.
- R8: A write to ID 4, 5 or 22 with `priv` low leaves the register unchanged. It raises `wr_err` for exactly the one cycle after that edge.
- R9: A write and a tick on the same edge store the written value. A tick that coincides with a write to ID 5 does not carry into the seconds register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Advance clock and down-counter on this edge |
| priv | input | 1 | Access is privileged |
| spr_id | input | 10 | Register ID for read and write |
| spr_we | input | 1 | Write strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Combinational read data for `spr_id` |
| irq_ack | input | 1 | Clear the pending interrupt request |
| irq | output | 1 | Pending down-counter interrupt request |
| wr_err | output | 1 | One-cycle pulse after a write refused for lack of privilege |

## Verification
Read data depends only on the present `spr_id` and `priv` and on register state, with no register in the read path. The bench therefore samples it one time unit after it changes the inputs, at the falling edge. Register updates from a tick or a write, the `irq` set and clear, and the `wr_err` pulse all come from one register stage. The bench checks them at the falling edge after the rising edge that sampled the stimulus, and checks `wr_err` exactly in that window, before it clears. Multi-tick results are sampled only after the counted number of ticking edges has passed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SPR_ID_W = 10;
  localparam logic [SPR_ID_W-1:0] ID_SEC     = 10'd4;
  localparam logic [SPR_ID_W-1:0] ID_NS      = 10'd5;
  localparam logic [SPR_ID_W-1:0] ID_DEC_USR = 10'd6;
  localparam logic [SPR_ID_W-1:0] ID_DEC     = 10'd22;

  function automatic logic [31:0] band_mask(input int lo, input int hi);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction
endpackage

// File: rtl/rtc_reset_sync.sv
module rtc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_wall_clock.sv
module rtc_wall_clock #(
  parameter int          W        = 32,
  parameter int unsigned STEP_NS  = 128,
  parameter int unsigned NS_WRAP  = 1000000000,
  parameter logic [W-1:0] NS_MASK = 32'h3FFF_FF80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ns_we,
  input  logic         sec_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ns_q,
  output logic [W-1:0] sec_q
);
  localparam logic [W:0] STEP_X = (W+1)'(STEP_NS);
  localparam logic [W:0] WRAP_X = (W+1)'(NS_WRAP);

  logic [W:0]   ns_sum;
  logic         carry;
  logic [W-1:0] ns_d, sec_d;
  logic         ns_en, sec_en;

  always_comb begin
    ns_sum = {1'b0, ns_q} + STEP_X;
    carry  = tick && (ns_sum >= WRAP_X);
    ns_d   = ns_q;
    sec_d  = sec_q;
    if (ns_we)      ns_d = wdata & NS_MASK;
    else if (carry) ns_d = W'(ns_sum - WRAP_X);
    else if (tick)  ns_d = ns_sum[W-1:0];
    if (sec_we)                sec_d = wdata;
    else if (carry && !ns_we)  sec_d = sec_q + 1'b1;
    ns_en  = ns_we || tick;
    sec_en = sec_we || (carry && !ns_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      if (ns_en)  ns_q  <= ns_d;
      if (sec_en) sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/rtc_down_counter.sv
module rtc_down_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  output logic [W-1:0] cnt_q,
  output logic         irq_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_en, wrap, irq_d;

  always_comb begin
    wrap   = tick && !we && (cnt_q == '0);
    cnt_en = we || tick;
    cnt_d  = we ? wdata : cnt_q - 1'b1;
    if (wrap)     irq_d = 1'b1;
    else if (ack) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SPR_ID_W-1:0] spr_id,
  input  logic                spr_we,
  input  logic                priv,
  input  logic [W-1:0]        ns_q,
  input  logic [W-1:0]        sec_q,
  input  logic [W-1:0]        dec_q,
  output logic                ns_we,
  output logic                sec_we,
  output logic                dec_we,
  output logic [W-1:0]        rdata,
  output logic                wr_err
);
  logic guarded, err_d;

  always_comb begin
    guarded = (spr_id == ID_SEC) || (spr_id == ID_NS) || (spr_id == ID_DEC);
    ns_we   = spr_we && priv && (spr_id == ID_NS);
    sec_we  = spr_we && priv && (spr_id == ID_SEC);
    dec_we  = spr_we && priv && (spr_id == ID_DEC);
    err_d   = spr_we && !priv && guarded;
    unique case (spr_id)
      ID_SEC:     rdata = sec_q;
      ID_NS:      rdata = ns_q;
      ID_DEC:     rdata = priv ? dec_q : '0;
      ID_DEC_USR: rdata = dec_q;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= err_d;
  end
endmodule

// File: rtl/rtc_dec_unit.sv
module rtc_dec_unit
  import rtc_pkg::*;
#(
  parameter int          W         = 32,
  parameter int unsigned STEP_NS   = 128,
  parameter int unsigned NS_WRAP   = 1000000000,
  parameter int          NS_LO_BIT = 7,
  parameter int          NS_HI_BIT = 29,
  parameter int          SYNC_LEN  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                priv,
  input  logic [SPR_ID_W-1:0] spr_id,
  input  logic                spr_we,
  input  logic [W-1:0]        spr_wdata,
  output logic [W-1:0]        spr_rdata,
  input  logic                irq_ack,
  output logic                irq,
  output logic                wr_err
);
  localparam logic [W-1:0] NS_MASK = W'(band_mask(NS_LO_BIT, NS_HI_BIT));

  logic         rst_int_n;
  logic         ns_we, sec_we, dec_we;
  logic [W-1:0] ns_q, sec_q, dec_q;

  rtc_reset_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  rtc_wall_clock #(.W(W), .STEP_NS(STEP_NS), .NS_WRAP(NS_WRAP), .NS_MASK(NS_MASK)) u_clock (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_en), .ns_we(ns_we), .sec_we(sec_we),
    .wdata(spr_wdata), .ns_q(ns_q), .sec_q(sec_q)
  );

  rtc_down_counter #(.W(W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_en), .we(dec_we), .wdata(spr_wdata),
    .ack(irq_ack), .cnt_q(dec_q), .irq_q(irq)
  );

  rtc_reg_port #(.W(W)) u_port (
    .clk(clk), .rst_n(rst_int_n), .spr_id(spr_id), .spr_we(spr_we), .priv(priv),
    .ns_q(ns_q), .sec_q(sec_q), .dec_q(dec_q), .ns_we(ns_we), .sec_we(sec_we),
    .dec_we(dec_we), .rdata(spr_rdata), .wr_err(wr_err)
  );
endmodule

// File: rtl/rtc_dec_unit_chk.sv
module rtc_dec_unit_chk
  import rtc_pkg::*;
#(
  parameter int W         = 32,
  parameter int NS_LO_BIT = 7,
  parameter int NS_HI_BIT = 29
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                priv,
  input logic [SPR_ID_W-1:0] spr_id,
  input logic                spr_we,
  input logic [W-1:0]        spr_rdata,
  input logic                irq_ack,
  input logic                irq,
  input logic                wr_err
);
  localparam logic [W-1:0] MASK = W'(band_mask(NS_LO_BIT, NS_HI_BIT));

  logic [2:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  // R2: nanosecond register never shows bits outside its band
  assert_ns_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_id == ID_NS) |-> ((spr_rdata & ~MASK) == '0));

  // R5: consecutive user-ID reads across a tick without a write differ by one
  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 3'd5 && spr_id == ID_DEC_USR && $past(spr_id == ID_DEC_USR)
     && $past(tick_en) && !$past(spr_we))
    |-> (spr_rdata == $past(spr_rdata) - 1'b1));

  // R6: pending request survives until acknowledged
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R6: request only rises after a ticking edge
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_en));

  // R8: error pulse follows an unprivileged write
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($past(spr_we) && !$past(priv)));
endmodule

bind rtc_dec_unit rtc_dec_unit_chk #(.W(W), .NS_LO_BIT(NS_LO_BIT), .NS_HI_BIT(NS_HI_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .priv(priv), .spr_id(spr_id),
  .spr_we(spr_we), .spr_rdata(spr_rdata), .irq_ack(irq_ack), .irq(irq), .wr_err(wr_err)
);

// File: tb/rtc_dec_unit_test.sv
module rtc_dec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, priv = 1'b0, spr_we = 1'b0, irq_ack = 1'b0;
  logic [9:0]  spr_id = '0;
  logic [31:0] spr_wdata = '0;
  logic [31:0] spr_rdata;
  logic        irq, wr_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_dec_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .priv(priv), .spr_id(spr_id),
    .spr_we(spr_we), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
    .irq_ack(irq_ack), .irq(irq), .wr_err(wr_err)
  );

  // {we, priv, id, wdata, expected read (privileged, same id), expected wr_err}
  localparam int NV = 8;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 1'b1, 10'd5,  32'hFFFF_FFFF, 32'h3FFF_FF80, 1'b0},
    {1'b1, 1'b1, 10'd4,  32'h1234_5678, 32'h1234_5678, 1'b0},
    {1'b1, 1'b1, 10'd22, 32'h0000_0010, 32'h0000_0010, 1'b0},
    {1'b1, 1'b0, 10'd22, 32'h0000_0055, 32'h0000_0010, 1'b1},
    {1'b1, 1'b0, 10'd5,  32'h0000_0000, 32'h3FFF_FF80, 1'b1},
    {1'b1, 1'b1, 10'd6,  32'h0000_0099, 32'h0000_0010, 1'b0},
    {1'b1, 1'b1, 10'd9,  32'h0000_ABCD, 32'h0000_0000, 1'b0},
    {1'b1, 1'b0, 10'd4,  32'h0000_0000, 32'h1234_5678, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] id, input logic [31:0] d, input logic p, output logic err);
    @(negedge clk);
    spr_we = 1'b1; spr_id = id; spr_wdata = d; priv = p;
    @(negedge clk);
    err = wr_err;
    spr_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] id, input logic p, output logic [31:0] v);
    @(negedge clk);
    spr_id = id; priv = p;
    #1 v = spr_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(10'd5, 1'b1, v);  check("R1 ns", v, 32'h0);
    rd(10'd4, 1'b1, v);  check("R1 sec", v, 32'h0);
    rd(10'd22, 1'b1, v); check("R1 dec", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 wr_err", {31'h0, wr_err}, 32'h0);

    // Table: R4 masking, R7 ID 6 and unused IDs, R8 unprivileged writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][74:65], VEC[i][64:33], VEC[i][75], e);
      check("R8 vector wr_err", {31'h0, e}, {31'h0, VEC[i][0]});
      rd(VEC[i][74:65], 1'b1, v);
      check("R4 R7 R8 vector read", v, VEC[i][32:1]);
    end

    // R2, R5 plain ticking
    wr(10'd5, 32'h0, 1'b1, e);
    wr(10'd22, 32'd1000, 1'b1, e);
    ticks(10);
    rd(10'd5, 1'b1, v);  check("R2 ns after 10 ticks", v, 32'd1280);
    rd(10'd22, 1'b1, v); check("R5 dec after 10 ticks", v, 32'd990);

    // R3 rollover
    wr(10'd5, 32'd999999872, 1'b1, e);
    wr(10'd4, 32'd5, 1'b1, e);
    ticks(1);
    rd(10'd5, 1'b1, v); check("R3 ns wraps", v, 32'd0);
    rd(10'd4, 1'b1, v); check("R3 sec carry", v, 32'd6);
    ticks(1);
    rd(10'd5, 1'b1, v); check("R2 ns after wrap", v, 32'd128);
    rd(10'd4, 1'b1, v); check("R3 no extra carry", v, 32'd6);

    // R3 out-of-range start
    wr(10'd5, 32'hFFFF_FFFF, 1'b1, e);
    ticks(1);
    rd(10'd5, 1'b1, v); check("R3 over-range ns", v, 32'h0465_3600);
    rd(10'd4, 1'b1, v); check("R3 over-range sec", v, 32'd7);

    // R5, R6 wrap and interrupt
    wr(10'd22, 32'd2, 1'b1, e);
    ticks(2);
    rd(10'd22, 1'b1, v); check("R5 dec at zero", v, 32'h0);
    check("R6 irq before wrap", {31'h0, irq}, 32'h0);
    ticks(1);
    rd(10'd22, 1'b1, v); check("R5 dec wrap", v, 32'hFFFF_FFFF);
    check("R6 irq set", {31'h0, irq}, 32'h1);
    ticks(3);
    check("R6 irq held", {31'h0, irq}, 32'h1);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R6 irq cleared", {31'h0, irq}, 32'h0);
    ticks(2);
    check("R6 no retrigger", {31'h0, irq}, 32'h0);

    // R6 ack and wrap on the same edge
    wr(10'd22, 32'd0, 1'b1, e);
    ticks(1);
    check("R6 irq set again", {31'h0, irq}, 32'h1);
    wr(10'd22, 32'd0, 1'b1, e);
    @(negedge clk) begin irq_ack = 1'b1; tick_en = 1'b1; end
    @(negedge clk) begin irq_ack = 1'b0; tick_en = 1'b0; end
    check("R6 wrap beats ack", {31'h0, irq}, 32'h1);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;

    // R9 write and tick on the same edge
    @(negedge clk) begin
      tick_en = 1'b1; spr_we = 1'b1; spr_id = 10'd22; spr_wdata = 32'd100; priv = 1'b1;
    end
    @(negedge clk) begin tick_en = 1'b0; spr_we = 1'b0; end
    rd(10'd22, 1'b1, v); check("R9 dec write wins", v, 32'd100);
    wr(10'd4, 32'd9, 1'b1, e);
    wr(10'd5, 32'd999999872, 1'b1, e);
    @(negedge clk) begin
      tick_en = 1'b1; spr_we = 1'b1; spr_id = 10'd5; spr_wdata = 32'd256; priv = 1'b1;
    end
    @(negedge clk) begin tick_en = 1'b0; spr_we = 1'b0; end
    rd(10'd5, 1'b1, v); check("R9 ns write wins", v, 32'd256);
    rd(10'd4, 1'b1, v); check("R9 no carry on write", v, 32'd9);

    // R7 unprivileged reads
    rd(10'd22, 1'b0, v); check("R7 ID 22 hidden", v, 32'h0);
    rd(10'd6, 1'b0, v);  check("R7 ID 6 visible", v, 32'd99);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule